// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block holds a small, fully associative table of segment descriptors for an address translation unit. Each slot keeps two 64-bit words: an effective-segment word, whose upper bits name the segment and whose bit 27 marks the slot valid, and a virtual-segment word whose top two bits give the segment size. Every slot is compared in parallel against an incoming effective address. Each slot is compared at 256 MB or 1 TB granularity, as its own size field selects.

Software-style operations arrive on separate request ports. A lookup port finds the segment for an address and returns the virtual-segment word, or all ones on a miss. A store port writes one slot after it has checked the operand. A read-back port returns either word of a slot. An invalidation port clears one matching segment or the whole table. When an invalidation actually drops a valid entry, the block requests a flush of the downstream translation cache, either local or global. The page-size decode is done outside the block. Only its verdict enters, as a single valid flag.

Top module: `slb_array`

## Requirements
- R1: After reset every slot holds zero in both words, so every lookup misses and every in-range read-back returns zero. No done or flush output is active.
- R2: Lookup forms two keys from the address. The 256 MB key is address bits 63:28 with bit 27 set and the lower bits cleared. The 1 TB key is address bits 63:40 with bit 27 set and the lower bits cleared. A slot hits when its size field (VSID word bits 63:62) is 00 and its ESID word equals the 256 MB key, or when the field is 01 and the word equals the 1 TB key.
- R3: When several slots hit, the lowest-numbered one is reported.
- R4: One cycle after `lk_req`, `lk_done` pulses with the hit flag, the slot and the VSID word. On a miss the slot reads 0 and the VSID reads all ones.
- R5: When `lk_mode64` is low, address bits 63:32 are treated as zero before the compare.
- R6: A store takes the slot from operand bits 11:0. The ESID word is the operand with bits 11:0 cleared, and bit 27 is the valid flag. The slot is written at the next clock edge, and `wr_done` pulses one cycle after the request with `wr_err` low.
- R7: A store is rejected (`wr_err` high, slot unchanged) in five cases: the slot is not below the table size; operand bits 26:12 are not zero; the size field is 10 or 11; the size field is 01 while `seg1t_en` is low; `wr_pgsz_ok` is low.
- R8: One cycle after `rd_req`, `rd_done` pulses. `rd_data` returns the ESID word when `rd_sel_vsid` is 0 and the VSID word when it is 1. A slot field not below the table size gives `rd_err` high and zero data.
- R9: A single-address invalidation looks up `inv_addr` in 64-bit form. On a hit it clears bit 27 of the winning slot and pulses `flush_local`, or `flush_global` if `inv_global` is set, one cycle later. On a miss it changes nothing and raises no flush.
- R10: Invalidate-all clears bit 27 in slots 1 to N-1 and never changes slot 0. It pulses `flush_local` only when at least one of those slots was valid.
- R11: When an invalidation and a store arrive in the same cycle, the invalidation is applied and the store is rejected with `wr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg1t_en | input | 1 | Permits stores of 1 TB segments |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 64 | Lookup effective address |
| lk_mode64 | input | 1 | 64-bit addressing; low means truncate to 32 bits |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a segment |
| lk_slot | output | IDX_W | Winning slot |
| lk_vsid | output | 64 | VSID word of the winner, all ones on miss |
| wr_req | input | 1 | Store request |
| wr_operand | input | 64 | Slot in bits 11:0, ESID word above |
| wr_vsid | input | 64 | VSID word to store |
| wr_pgsz_ok | input | 1 | External verdict that the page-size encoding is legal |
| wr_done | output | 1 | Store result valid |
| wr_err | output | 1 | Store rejected |
| rd_req | input | 1 | Read-back request |
| rd_slot | input | 12 | Slot field of the read-back operand |
| rd_sel_vsid | input | 1 | 0 selects the ESID word, 1 the VSID word |
| rd_done | output | 1 | Read-back result valid |
| rd_err | output | 1 | Slot out of range |
| rd_data | output | 64 | Read-back word |
| inv_req | input | 1 | Invalidation request |
| inv_all | input | 1 | Invalidate every slot except slot 0 |
| inv_global | input | 1 | Single-address form requests a global flush |
| inv_addr | input | 64 | Address to invalidate |
| flush_local | output | 1 | Local translation-cache flush request |
| flush_global | output | 1 | Global translation-cache flush request |

## Verification
The hardest case to reach is an address that matches slots of both granularities. A 1 TB slot and a 256 MB slot must both hit, so the winner is decided only by slot number. The stimulus stores a 1 TB segment in a lower slot and a 256 MB segment covering the same address in a higher slot, with a duplicated 256 MB pair next to it. A second subtle case is an invalidate-all that leaves only slot 0 valid, which must raise no flush. The stimulus reaches it by filling slot 0, invalidating everything once, and then repeating the command.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int EA_W         = 64;
  localparam int SLOT_FIELD_W = 12;
  localparam int VALID_BIT    = 27;
  localparam int SEG256_SH    = 28;
  localparam int SEG1T_SH     = 40;
  localparam int SIZE_LO      = 62;

  typedef logic [EA_W-1:0] word_t;

  typedef enum logic [1:0] {
    SEG_256M = 2'b00,
    SEG_1T   = 2'b01
  } seg_size_e;

  // Compare key: address bits at or above sh, valid flag set, rest zero.
  function automatic word_t seg_key(input word_t ea, input int sh);
    word_t k;
    k = ea & ~((word_t'(1) << sh) - word_t'(1));
    k[VALID_BIT] = 1'b1;
    return k;
  endfunction
endpackage

// File: rtl/slb_rst_sync.sv
module slb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/slb_match.sv
module slb_match
  import slb_pkg::*;
#(
  parameter  int ENTRIES = 32,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ENTRIES-1:0][EA_W-1:0]     esid_tab,
  input  logic [ENTRIES-1:0][1:0]          size_tab,
  input  logic [EA_W-1:0]                  addr,
  output logic                             hit,
  output logic [IDX_W-1:0]                 idx
);
  logic [EA_W-1:0]    key_256m;
  logic [EA_W-1:0]    key_1t;
  logic [ENTRIES-1:0] match_vec;

  assign key_256m = seg_key(addr, SEG256_SH);
  assign key_1t   = seg_key(addr, SEG1T_SH);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] =
        ((size_tab[g] == SEG_256M) && (esid_tab[g] == key_256m)) ||
        ((size_tab[g] == SEG_1T)   && (esid_tab[g] == key_1t));
  end

  // Lowest-numbered matching slot wins.
  always_comb begin
    hit = |match_vec;
    idx = '0;
    for (int j = ENTRIES - 1; j >= 0; j--) begin
      if (match_vec[j]) begin
        idx = IDX_W'(j);
      end
    end
  end

  AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> esid_tab[idx][VALID_BIT]);  // R2
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check
  import slb_pkg::*;
#(
  parameter  int ENTRIES = 32,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [SLOT_FIELD_W-1:0]           slot_field,
  input  logic [VALID_BIT-1:SLOT_FIELD_W]   rsvd_bits,
  input  logic [1:0]                        size_field,
  input  logic                              pgsz_ok,
  input  logic                              seg1t_en,
  output logic                              ok,
  output logic [IDX_W-1:0]                  slot
);
  logic slot_ok;
  logic rsvd_ok;
  logic size_ok;

  assign slot_ok = {{(32-SLOT_FIELD_W){1'b0}}, slot_field} < 32'(ENTRIES);
  assign rsvd_ok = (rsvd_bits == '0);
  assign size_ok = (size_field == SEG_256M) ||
                   ((size_field == SEG_1T) && seg1t_en);
  assign ok      = slot_ok && rsvd_ok && size_ok && pgsz_ok;
  assign slot    = slot_field[IDX_W-1:0];
endmodule

// File: rtl/slb_array.sv
module slb_array
  import slb_pkg::*;
#(
  parameter  int ENTRIES = 32,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seg1t_en,
  input  logic                    lk_req,
  input  logic [63:0]             lk_addr,
  input  logic                    lk_mode64,
  output logic                    lk_done,
  output logic                    lk_hit,
  output logic [IDX_W-1:0]        lk_slot,
  output logic [63:0]             lk_vsid,
  input  logic                    wr_req,
  input  logic [63:0]             wr_operand,
  input  logic [63:0]             wr_vsid,
  input  logic                    wr_pgsz_ok,
  output logic                    wr_done,
  output logic                    wr_err,
  input  logic                    rd_req,
  input  logic [11:0]             rd_slot,
  input  logic                    rd_sel_vsid,
  output logic                    rd_done,
  output logic                    rd_err,
  output logic [63:0]             rd_data,
  input  logic                    inv_req,
  input  logic                    inv_all,
  input  logic                    inv_global,
  input  logic [63:0]             inv_addr,
  output logic                    flush_local,
  output logic                    flush_global
);
  logic rst_q_n;

  slb_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  // Table state
  logic [ENTRIES-1:0][EA_W-1:0] esid_q, esid_d;
  logic [ENTRIES-1:0][EA_W-1:0] vsid_q, vsid_d;
  logic [ENTRIES-1:0][1:0]      size_tab;
  logic                         tab_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_size
    assign size_tab[g] = vsid_q[g][EA_W-1:SIZE_LO];
  end

  // Lookup path
  logic [EA_W-1:0]  lk_ea;
  logic             lk_match;
  logic [IDX_W-1:0] lk_idx;

  assign lk_ea = lk_mode64 ? lk_addr : {{(EA_W-32){1'b0}}, lk_addr[31:0]};

  slb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .esid_tab (esid_q),
    .size_tab (size_tab),
    .addr     (lk_ea),
    .hit      (lk_match),
    .idx      (lk_idx)
  );

  // Invalidation path
  logic             inv_match;
  logic [IDX_W-1:0] inv_idx;

  slb_match #(.ENTRIES(ENTRIES)) u_inv_match (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .esid_tab (esid_q),
    .size_tab (size_tab),
    .addr     (inv_addr),
    .hit      (inv_match),
    .idx      (inv_idx)
  );

  // Store validation
  logic             wr_ok;
  logic [IDX_W-1:0] wr_idx;
  logic [EA_W-1:0]  wr_esid;

  slb_wr_check #(.ENTRIES(ENTRIES)) u_wr_check (
    .slot_field (wr_operand[SLOT_FIELD_W-1:0]),
    .rsvd_bits  (wr_operand[VALID_BIT-1:SLOT_FIELD_W]),
    .size_field (wr_vsid[EA_W-1:SIZE_LO]),
    .pgsz_ok    (wr_pgsz_ok),
    .seg1t_en   (seg1t_en),
    .ok         (wr_ok),
    .slot       (wr_idx)
  );

  assign wr_esid = {wr_operand[EA_W-1:SLOT_FIELD_W], {SLOT_FIELD_W{1'b0}}};

  // Read-back decode
  logic             rd_ok;
  logic [IDX_W-1:0] rd_idx;

  assign rd_ok  = {{(32-SLOT_FIELD_W){1'b0}}, rd_slot} < 32'(ENTRIES);
  assign rd_idx = rd_slot[IDX_W-1:0];

  // Response registers
  logic             lk_done_q, lk_hit_q;
  logic [IDX_W-1:0] lk_slot_q;
  logic [EA_W-1:0]  lk_vsid_q;
  logic             lk_hit_d;
  logic [IDX_W-1:0] lk_slot_d;
  logic [EA_W-1:0]  lk_vsid_d;
  logic             wr_done_q, wr_err_q, wr_err_d;
  logic             rd_done_q, rd_err_q, rd_err_d;
  logic [EA_W-1:0]  rd_data_q, rd_data_d;
  logic             fl_q, fg_q, fl_d, fg_d;

  // Next-state: table update
  always_comb begin
    esid_d = esid_q;
    vsid_d = vsid_q;
    fl_d   = 1'b0;
    fg_d   = 1'b0;
    if (inv_req) begin
      if (inv_all) begin
        for (int i = 1; i < ENTRIES; i++) begin
          if (esid_q[i][VALID_BIT]) begin
            esid_d[i][VALID_BIT] = 1'b0;
            fl_d                 = 1'b1;
          end
        end
      end else if (inv_match) begin
        esid_d[inv_idx][VALID_BIT] = 1'b0;
        if (inv_global) begin
          fg_d = 1'b1;
        end else begin
          fl_d = 1'b1;
        end
      end
    end else if (wr_req && wr_ok) begin
      esid_d[wr_idx] = wr_esid;
      vsid_d[wr_idx] = wr_vsid;
    end
  end

  assign tab_en = inv_req || (wr_req && wr_ok);

  // Next-state: responses
  always_comb begin
    lk_hit_d  = lk_match;
    lk_slot_d = lk_match ? lk_idx : '0;
    lk_vsid_d = lk_match ? vsid_q[lk_idx] : '1;
    wr_err_d  = !wr_ok || inv_req;
    rd_err_d  = !rd_ok;
    rd_data_d = '0;
    if (rd_ok) begin
      rd_data_d = rd_sel_vsid ? vsid_q[rd_idx] : esid_q[rd_idx];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      esid_q <= '0;
      vsid_q <= '0;
    end else if (tab_en) begin
      esid_q <= esid_d;
      vsid_q <= vsid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lk_done_q <= 1'b0;
      wr_done_q <= 1'b0;
      rd_done_q <= 1'b0;
      fl_q      <= 1'b0;
      fg_q      <= 1'b0;
    end else begin
      lk_done_q <= lk_req;
      wr_done_q <= wr_req;
      rd_done_q <= rd_req;
      fl_q      <= fl_d;
      fg_q      <= fg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lk_hit_q  <= 1'b0;
      lk_slot_q <= '0;
      lk_vsid_q <= '0;
    end else if (lk_req) begin
      lk_hit_q  <= lk_hit_d;
      lk_slot_q <= lk_slot_d;
      lk_vsid_q <= lk_vsid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wr_err_q <= 1'b0;
    end else if (wr_req) begin
      wr_err_q <= wr_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_err_q  <= 1'b0;
      rd_data_q <= '0;
    end else if (rd_req) begin
      rd_err_q  <= rd_err_d;
      rd_data_q <= rd_data_d;
    end
  end

  assign lk_done      = lk_done_q;
  assign lk_hit       = lk_hit_q;
  assign lk_slot      = lk_slot_q;
  assign lk_vsid      = lk_vsid_q;
  assign wr_done      = wr_done_q;
  assign wr_err       = wr_err_q;
  assign rd_done      = rd_done_q;
  assign rd_err       = rd_err_q;
  assign rd_data      = rd_data_q;
  assign flush_local  = fl_q;
  assign flush_global = fg_q;

  // Assertions
  AST_SLOT0_KEPT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (inv_req && inv_all) |=> $stable(esid_q[0]));  // R10

  AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({flush_local, flush_global}));  // R9

  AST_INV_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (inv_req && !inv_all && !inv_match) |=> (!flush_local && !flush_global));  // R9

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_req && !wr_ok && !inv_req) |=> ($stable(esid_q) && $stable(vsid_q)));  // R7

  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_req && wr_vsid[EA_W-1]) |=> (wr_done && wr_err));  // R7

  AST_CONCURRENT_REJECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_req && inv_req) |=> wr_err);  // R11

  AST_LK_PULSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    lk_req |=> lk_done);  // R4

  AST_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lk_req && !lk_match) |=> (lk_vsid == '1));  // R4
endmodule

// File: tb/test_slb_array.sv
module test_slb_array;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 32;
  localparam int IDX_W      = $clog2(ENTRIES);

  logic              clk;
  logic              rst_n;
  logic              seg1t_en;
  logic              lk_req;
  logic [63:0]       lk_addr;
  logic              lk_mode64;
  logic              lk_done;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_slot;
  logic [63:0]       lk_vsid;
  logic              wr_req;
  logic [63:0]       wr_operand;
  logic [63:0]       wr_vsid;
  logic              wr_pgsz_ok;
  logic              wr_done;
  logic              wr_err;
  logic              rd_req;
  logic [11:0]       rd_slot;
  logic              rd_sel_vsid;
  logic              rd_done;
  logic              rd_err;
  logic [63:0]       rd_data;
  logic              inv_req;
  logic              inv_all;
  logic              inv_global;
  logic [63:0]       inv_addr;
  logic              flush_local;
  logic              flush_global;

  slb_array #(.ENTRIES(ENTRIES)) i_slb_array (
    .clk (clk), .rst_n (rst_n), .seg1t_en (seg1t_en),
    .lk_req (lk_req), .lk_addr (lk_addr), .lk_mode64 (lk_mode64),
    .lk_done (lk_done), .lk_hit (lk_hit), .lk_slot (lk_slot), .lk_vsid (lk_vsid),
    .wr_req (wr_req), .wr_operand (wr_operand), .wr_vsid (wr_vsid),
    .wr_pgsz_ok (wr_pgsz_ok), .wr_done (wr_done), .wr_err (wr_err),
    .rd_req (rd_req), .rd_slot (rd_slot), .rd_sel_vsid (rd_sel_vsid),
    .rd_done (rd_done), .rd_err (rd_err), .rd_data (rd_data),
    .inv_req (inv_req), .inv_all (inv_all), .inv_global (inv_global),
    .inv_addr (inv_addr), .flush_local (flush_local), .flush_global (flush_global)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ntests = 0;
  int nfail  = 0;
  bit done_flag = 0;

  // Scoreboard item: 0 lookup, 1 read-back, 2 store, 3 invalidation
  typedef struct {
    int          kind;
    bit          hit;
    int          slot;
    logic [63:0] data;
    bit          err;
    bit          fl;
    bit          fg;
    longint      due;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // Reference table built from the requirements
  logic [63:0] esid_m [ENTRIES];
  logic [63:0] vsid_m [ENTRIES];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  endtask

  function automatic bit m_match(input int i, input logic [63:0] a);
    logic [1:0] sz;
    sz = vsid_m[i][63:62];
    if (sz == 2'b00)
      return (esid_m[i][63:28] == a[63:28]) && (esid_m[i][27:0] == 28'h800_0000);
    if (sz == 2'b01)
      return (esid_m[i][63:40] == a[63:40]) && (esid_m[i][39:0] == 40'h00_0800_0000);
    return 1'b0;
  endfunction

  task automatic m_find(input logic [63:0] a, output bit h, output int s);
    h = 0;
    s = 0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m_match(i, a)) begin
        h = 1;
        s = i;
      end
    end
  endtask

  // Monitor: compare responses when due
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      e = sb.pop_front();
      case (e.kind)
        0: begin
          check(lk_done == 1'b1, e.tag, "lk_done", 64'(lk_done), 64'd1);
          check(lk_hit == e.hit, e.tag, "lk_hit", 64'(lk_hit), 64'(e.hit));
          check(int'(lk_slot) == e.slot, e.tag, "lk_slot", 64'(lk_slot), 64'(e.slot));
          check(lk_vsid == e.data, e.tag, "lk_vsid", lk_vsid, e.data);
        end
        1: begin
          check(rd_done && (rd_err == e.err), e.tag, "rd_done/rd_err",
                {62'd0, rd_done, rd_err}, {62'd0, 1'b1, e.err});
          check(rd_data == e.data, e.tag, "rd_data", rd_data, e.data);
        end
        2: begin
          check(wr_done && (wr_err == e.err), e.tag, "wr_done/wr_err",
                {62'd0, wr_done, wr_err}, {62'd0, 1'b1, e.err});
        end
        default: begin
          check((flush_local == e.fl) && (flush_global == e.fg), e.tag,
                "flush local/global", {62'd0, flush_local, flush_global},
                {62'd0, e.fl, e.fg});
        end
      endcase
    end
  end

  task automatic do_lookup(input logic [63:0] a, input bit m64, input string tag);
    exp_t e;
    bit h;
    int s;
    logic [63:0] ea;
    ea = m64 ? a : {32'h0, a[31:0]};
    m_find(ea, h, s);
    e.kind = 0;
    e.hit  = h;
    e.slot = h ? s : 0;
    e.data = h ? vsid_m[s] : '1;
    e.err  = 0;
    e.fl   = 0;
    e.fg   = 0;
    e.due  = cyc + 1;
    e.tag  = tag;
    sb.push_back(e);
    lk_req    = 1'b1;
    lk_addr   = a;
    lk_mode64 = m64;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] s, input bit sel, input string tag);
    exp_t e;
    e.kind = 1;
    e.hit  = 0;
    e.slot = 0;
    e.err  = (int'(s) >= ENTRIES);
    e.data = e.err ? 64'd0 : (sel ? vsid_m[int'(s)] : esid_m[int'(s)]);
    e.fl   = 0;
    e.fg   = 0;
    e.due  = cyc + 1;
    e.tag  = tag;
    sb.push_back(e);
    rd_req      = 1'b1;
    rd_slot     = s;
    rd_sel_vsid = sel;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic do_update(input bit inv, input bit all, input bit glob,
                           input logic [63:0] ia, input bit wr,
                           input logic [63:0] op, input logic [63:0] v,
                           input bit pg, input string tag);
    exp_t e;
    bit h;
    int s;
    bit bad;
    e.hit  = 0;
    e.slot = 0;
    e.data = '0;
    e.err  = 0;
    e.fl   = 0;
    e.fg   = 0;
    e.due  = cyc + 1;
    e.tag  = tag;
    if (inv) begin
      e.kind = 3;
      if (all) begin
        for (int i = 1; i < ENTRIES; i++) begin
          if (esid_m[i][27]) begin
            esid_m[i][27] = 1'b0;
            e.fl = 1;
          end
        end
      end else begin
        m_find(ia, h, s);
        if (h) begin
          esid_m[s][27] = 1'b0;
          if (glob) e.fg = 1;
          else      e.fl = 1;
        end
      end
      sb.push_back(e);
    end
    if (wr) begin
      s   = int'(op[11:0]);
      bad = (s >= ENTRIES) || (op[26:12] != 15'd0) || v[63] ||
            ((v[63:62] == 2'b01) && !seg1t_en) || !pg;
      e.kind = 2;
      e.fl   = 0;
      e.fg   = 0;
      e.err  = bad || inv;
      if (!e.err) begin
        esid_m[s] = {op[63:12], 12'h000};
        vsid_m[s] = v;
      end
      sb.push_back(e);
    end
    inv_req    = inv;
    inv_all    = all;
    inv_global = glob;
    inv_addr   = ia;
    wr_req     = wr;
    wr_operand = op;
    wr_vsid    = v;
    wr_pgsz_ok = pg;
    @(negedge clk);
    inv_req = 1'b0;
    wr_req  = 1'b0;
  endtask

  task automatic do_write(input logic [63:0] op, input logic [63:0] v,
                          input bit pg, input string tag);
    do_update(0, 0, 0, 64'd0, 1, op, v, pg, tag);
  endtask

  task automatic do_inv(input bit all, input bit glob, input logic [63:0] a,
                        input string tag);
    do_update(1, all, glob, a, 0, 64'd0, 64'd0, 1'b1, tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    ntests++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    seg1t_en = 1'b1;
    lk_req = 1'b0; lk_addr = '0; lk_mode64 = 1'b1;
    wr_req = 1'b0; wr_operand = '0; wr_vsid = '0; wr_pgsz_ok = 1'b1;
    rd_req = 1'b0; rd_slot = '0; rd_sel_vsid = 1'b0;
    inv_req = 1'b0; inv_all = 1'b0; inv_global = 1'b0; inv_addr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      esid_m[i] = '0;
      vsid_m[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs and empty table
    check(!lk_done && !wr_done && !rd_done && !flush_local && !flush_global,
          "R1", "idle outputs", {59'd0, lk_done, wr_done, rd_done, flush_local, flush_global}, 64'd0);
    do_lookup(64'h1234_5678_9ABC_DEF0, 1, "R1 lookup after reset");
    do_read(12'd0, 0, "R1 read slot0");

    // R6 / R2: 256 MB entry in slot 3
    do_write(64'h1234_5678_9800_0003, 64'h0000_0000_00AB_C003, 1, "R6 store slot3");
    do_lookup(64'h1234_5678_9123_4567, 1, "R2 256M hit");
    do_lookup(64'h1234_5678_A000_0000, 1, "R2 256M neighbour miss");

    // R2: 1 TB entry in slot 5
    do_write(64'hABCD_EF00_0800_0005, 64'h4000_0000_0055_5005, 1, "R6 store 1T slot5");
    do_lookup(64'hABCD_EF7F_F123_0000, 1, "R2 1T hit");

    // R3: overlapping entries
    do_write(64'hABCD_EF7F_F800_0006, 64'h0000_0000_0066_6006, 1, "R6 store slot6");
    do_lookup(64'hABCD_EF7F_F123_0000, 1, "R3 1T beats 256M");
    do_write(64'h1234_5678_9800_0002, 64'h0000_0000_0022_2002, 1, "R6 store slot2");
    do_lookup(64'h1234_5678_9000_0000, 1, "R3 lowest slot");

    // R5: 32-bit truncation
    do_write(64'h0000_0000_3800_0009, 64'h0000_0000_0000_0999, 1, "R6 store slot9");
    do_lookup(64'hFFFF_FFFF_3000_0010, 0, "R5 32-bit hit");
    do_lookup(64'hFFFF_FFFF_3000_0010, 1, "R5 64-bit miss");

    // R7: rejected stores
    do_write(64'h1111_0000_0800_0028, 64'h0000_0000_0000_0001, 1, "R7 slot out of range");
    do_write(64'h1111_0000_0800_1007, 64'h0000_0000_0000_0001, 1, "R7 reserved bits");
    do_write(64'h1111_0000_0800_0007, 64'h8000_0000_0000_0001, 1, "R7 bad size");
    seg1t_en = 1'b0;
    do_write(64'h1111_0000_0800_0007, 64'h4000_0000_0000_0001, 1, "R7 1T disabled");
    seg1t_en = 1'b1;
    do_write(64'h1111_0000_0800_0007, 64'h0000_0000_0000_0001, 0, "R7 page size flag");
    do_read(12'd7, 0, "R7 slot7 esid unchanged");
    do_read(12'd7, 1, "R7 slot7 vsid unchanged");

    // R8: read-back
    do_read(12'd3, 0, "R8 esid slot3");
    do_read(12'd3, 1, "R8 vsid slot3");
    do_read(12'hFFF, 0, "R8 read out of range");
    do_read(12'd32, 1, "R8 read first illegal slot");

    // R9: single-address invalidation
    do_inv(0, 0, 64'h1234_5678_9000_0000, "R9 local invalidate");
    do_lookup(64'h1234_5678_9000_0000, 1, "R9 next slot after invalidate");
    do_read(12'd2, 0, "R9 valid bit cleared");
    do_inv(0, 1, 64'hABCD_EF7F_F000_0000, "R9 global invalidate");
    do_lookup(64'hABCD_EF7F_F000_0000, 1, "R9 after global invalidate");
    do_inv(0, 0, 64'h7777_0000_0000_0000, "R9 miss no flush");

    // R11: concurrent invalidation and store
    do_update(1, 0, 0, 64'h0000_0000_3000_0000, 1,
              64'h2222_0000_0800_000A, 64'h0000_0000_0000_0AAA, 1, "R11 concurrent");
    do_read(12'd10, 1, "R11 store dropped");
    do_lookup(64'h0000_0000_3000_0000, 1, "R11 invalidate applied");

    // R10: invalidate-all
    do_write(64'h5555_0000_0800_0000, 64'h0000_0000_0000_0F00, 1, "R6 store slot0");
    do_inv(1, 0, 64'd0, "R10 invalidate all");
    do_lookup(64'h5555_0000_0000_0001, 1, "R10 slot0 survives");
    do_lookup(64'h1234_5678_9000_0000, 1, "R10 others cleared");
    do_inv(1, 0, 64'd0, "R10 nothing left to clear");
    do_read(12'd0, 0, "R10 slot0 esid intact");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R4", "scoreboard drained", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule